// File: doc/BRIEF.md
# I2C SCL Timing Generator

This block generates the SCL clock timing for an I2C master. A programmable divider turns the source clock into a tick. Three counts, each measured in ticks, set the SCL waveform: the time SCL is driven low, the time it is held high, and the length of the whole period. Any part of the period count that the high and low counts do not use becomes extra low time. The counts arrive packed into one configuration word. The divider value and a serial-clock enable are separate inputs.

The block drives SCL low through an open-drain request and watches the real bus level. A target can stretch the clock by holding SCL low: the high phase does not start until SCL is seen high. Two strobes tell the data-path logic when to act on SDA. The data-change strobe fires halfway through the low phase. The sample strobe fires in the cycle SCL is first seen high. A new configuration word and a new divider value are taken only when a new SCL period begins.

Top module: `scl_timing_gen`

## Requirements
- R1: While reset is asserted, and afterwards until the enable is first set, `scl_pull_low` and both strobes are 0.
- R2: The configuration word carries the high count in bits [29:20], the low count in bits [19:10] and the period count in bits [9:0]. A count of 0 behaves as 1.
- R3: One tick lasts D source clocks, where D is the divider value. A divider value of 0 behaves as 1.
- R4: Each low phase lasts max(low, period - high) ticks, with zero counts taken as 1 as in R2. `scl_pull_low` stays 1 for exactly that many ticks times D clocks.
- R5: After SCL is released, the release interval is high*D + 1 + S clocks, where S is the number of released clocks in which the bus is still low. A new low phase follows at once.
- R6: While SCL is released but still low on the bus, the high count does not advance. The sample strobe waits until the first clock in which SCL reads high.
- R7: The data-change strobe fires exactly once per low phase. It falls on tick number ceil(N/2) of that phase, which is clock (ceil(N/2))*D of the phase, where N is the low-phase length in ticks.
- R8: The sample strobe fires exactly once per period, in the first released clock in which SCL reads high.
- R9: A configuration word or divider value applied during a period takes effect only at the start of the next period.
- R10: While the enable is clear, no tick occurs. Each clock of a low phase with the enable clear lengthens that phase by exactly one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_word | input | 30 | Packed high, low and period counts |
| div_value | input | 8 | Source clocks per tick (0 behaves as 1) |
| ser_clk_en | input | 1 | Serial clock enable; ticks stop while it is clear |
| scl_in | input | 1 | SCL level sampled from the bus |
| scl_pull_low | output | 1 | Request to drive SCL low (open drain) |
| sda_change_stb | output | 1 | SDA may change in this cycle |
| sda_sample_stb | output | 1 | SDA should be sampled in this cycle (SCL rising) |

## Verification
Two pairs of functions can fall in the same cycle. In the first, the enable gate lands on the cycle of the tick that would end the low phase or fire the mid-low strobe. The bench drops the enable partway through a long low phase and checks that the low phase grows by exactly the number of gated clocks and that the change strobe still fires once. In the second, a target's stretch coincides with the release of SCL. The bench holds the bus low across the release for a random number of clocks and checks that the sample strobe and the high count start in the first clock SCL reads high, never earlier.

// File: rtl/scl_timing_pkg.sv
package scl_timing_pkg;

  // Phase of the generated SCL waveform
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,   // out of reset, nothing generated yet
    PH_LOW  = 2'd1,   // SCL driven low
    PH_REL  = 2'd2,   // SCL released, waiting for the bus to read high
    PH_HIGH = 2'd3    // SCL high, high count running
  } scl_phase_e;

  localparam int SCL_CNT_W_DEF = 10;
  localparam int SCL_DIV_W_DEF = 8;

endpackage

// File: rtl/scl_tick_div.sv
module scl_tick_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_en,
  input  logic             restart,
  input  logic [DIV_W-1:0] div_val,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] last_cnt;

  // Terminal count of the divider; zero divides by one
  function automatic logic [DIV_W-1:0] term_count(input logic [DIV_W-1:0] d);
    return (d == '0) ? '0 : d - DIV_W'(1);
  endfunction

  assign last_cnt = term_count(div_val);
  // ">=" keeps the divider live if the terminal count shrinks
  assign tick     = ser_en && (cnt_q >= last_cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (restart) cnt_q <= '0;
    else if (!ser_en) cnt_q <= cnt_q;
    else if (tick)    cnt_q <= '0;
    else              cnt_q <= cnt_q + DIV_W'(1);
  end

endmodule

// File: rtl/scl_cfg_latch.sv
module scl_cfg_latch #(
  parameter int CNT_W = 10,
  parameter int DIV_W = 8,
  localparam int CFG_W = 3 * CNT_W,
  localparam int SPN_W = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CFG_W-1:0] cfg_word,
  input  logic [DIV_W-1:0] div_in,
  output logic [CNT_W-1:0] lat_high,
  output logic [CNT_W-1:0] lat_low,
  output logic [CNT_W-1:0] lat_cyc,
  output logic [DIV_W-1:0] lat_div,
  output logic [SPN_W-1:0] high_ticks,
  output logic [SPN_W-1:0] low_ticks,
  output logic [SPN_W-1:0] mid_tick
);

  // Zero count behaves as one tick
  function automatic logic [SPN_W-1:0] eff_count(input logic [CNT_W-1:0] v);
    return (v == '0) ? SPN_W'(1) : {1'b0, v};
  endfunction

  // Low span: unused period time is added to the low phase
  function automatic logic [SPN_W-1:0] low_span(input logic [CNT_W-1:0] h,
                                                input logic [CNT_W-1:0] l,
                                                input logic [CNT_W-1:0] c);
    logic [SPN_W-1:0] he, le, ce;
    logic [SPN_W:0]   both;
    he   = eff_count(h);
    le   = eff_count(l);
    ce   = {1'b0, c};
    both = {1'b0, he} + {1'b0, le};
    return ({1'b0, ce} > both) ? (ce - he) : le;
  endfunction

  // Tick number, counted from one, of the mid-low strobe: ceil(n/2)
  function automatic logic [SPN_W-1:0] mid_of(input logic [SPN_W-1:0] n);
    logic [SPN_W:0] s;
    s = {1'b0, n} + (SPN_W+1)'(1);
    return s[SPN_W:1];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_high <= '0;
      lat_low  <= '0;
      lat_cyc  <= '0;
      lat_div  <= '0;
    end else if (load) begin
      lat_high <= cfg_word[3*CNT_W-1:2*CNT_W];
      lat_low  <= cfg_word[2*CNT_W-1:CNT_W];
      lat_cyc  <= cfg_word[CNT_W-1:0];
      lat_div  <= div_in;
    end
  end

  assign high_ticks = eff_count(lat_high);
  assign low_ticks  = low_span(lat_high, lat_low, lat_cyc);
  assign mid_tick   = mid_of(low_ticks);

endmodule

// File: rtl/scl_phase_seq.sv
module scl_phase_seq
  import scl_timing_pkg::*;
#(
  parameter int CNT_W = 10,
  localparam int SPN_W = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_en,
  input  logic             tick,
  input  logic             scl_in,
  input  logic [SPN_W-1:0] high_ticks,
  input  logic [SPN_W-1:0] low_ticks,
  input  logic [SPN_W-1:0] mid_tick,
  output scl_phase_e       phase,
  output logic             period_start,
  output logic             enter_high,
  output logic             rel_wait,
  output logic             change_evt
);

  logic [SPN_W-1:0] ph_cnt_q;
  logic [SPN_W-1:0] nxt_cnt;
  logic             low_done;
  logic             high_done;
  logic             in_low;
  logic             in_high;

  assign in_low       = (phase == PH_LOW);
  assign in_high      = (phase == PH_HIGH);
  assign rel_wait     = (phase == PH_REL);
  assign nxt_cnt      = ph_cnt_q + SPN_W'(1);
  assign low_done     = in_low  && tick && (nxt_cnt == low_ticks);
  assign high_done    = in_high && tick && (nxt_cnt == high_ticks);
  assign enter_high   = rel_wait && scl_in;
  assign period_start = ((phase == PH_IDLE) && ser_en) || high_done;
  assign change_evt   = in_low && tick && (nxt_cnt == mid_tick);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      ph_cnt_q <= '0;
    end else if (period_start) begin
      phase    <= PH_LOW;
      ph_cnt_q <= '0;
    end else if (low_done) begin
      phase    <= PH_REL;
      ph_cnt_q <= '0;
    end else if (enter_high) begin
      phase    <= PH_HIGH;
      ph_cnt_q <= '0;
    end else if (tick && (in_low || in_high)) begin
      ph_cnt_q <= nxt_cnt;
    end
  end

endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
  import scl_timing_pkg::*;
#(
  parameter int CNT_W = SCL_CNT_W_DEF,
  parameter int DIV_W = SCL_DIV_W_DEF,
  localparam int CFG_W = 3 * CNT_W,
  localparam int SPN_W = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfg_word,
  input  logic [DIV_W-1:0] div_value,
  input  logic             ser_clk_en,
  input  logic             scl_in,
  output logic             scl_pull_low,
  output logic             sda_change_stb,
  output logic             sda_sample_stb
);

  // Named internal events, also watched by the bound checker
  logic             tick;
  logic             period_start;
  logic             enter_high;
  logic             rel_wait;
  logic             change_evt;
  logic             div_restart;
  scl_phase_e       phase;
  logic [CNT_W-1:0] lat_high;
  logic [CNT_W-1:0] lat_low;
  logic [CNT_W-1:0] lat_cyc;
  logic [DIV_W-1:0] lat_div;
  logic [SPN_W-1:0] high_ticks;
  logic [SPN_W-1:0] low_ticks;
  logic [SPN_W-1:0] mid_tick;

  // Each timed phase starts on a fresh tick boundary
  assign div_restart = period_start || enter_high;

  scl_cfg_latch #(.CNT_W(CNT_W), .DIV_W(DIV_W)) i_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (period_start),
    .cfg_word   (cfg_word),
    .div_in     (div_value),
    .lat_high   (lat_high),
    .lat_low    (lat_low),
    .lat_cyc    (lat_cyc),
    .lat_div    (lat_div),
    .high_ticks (high_ticks),
    .low_ticks  (low_ticks),
    .mid_tick   (mid_tick)
  );

  scl_tick_div #(.DIV_W(DIV_W)) i_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .ser_en  (ser_clk_en),
    .restart (div_restart),
    .div_val (lat_div),
    .tick    (tick)
  );

  scl_phase_seq #(.CNT_W(CNT_W)) i_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .ser_en       (ser_clk_en),
    .tick         (tick),
    .scl_in       (scl_in),
    .high_ticks   (high_ticks),
    .low_ticks    (low_ticks),
    .mid_tick     (mid_tick),
    .phase        (phase),
    .period_start (period_start),
    .enter_high   (enter_high),
    .rel_wait     (rel_wait),
    .change_evt   (change_evt)
  );

  assign scl_pull_low   = (phase == PH_LOW);
  assign sda_change_stb = change_evt;
  assign sda_sample_stb = enter_high;

endmodule

// File: rtl/scl_timing_chk.sv
module scl_timing_chk #(
  parameter int CNT_W = 10,
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ser_clk_en,
  input logic             scl_in,
  input logic             scl_pull_low,
  input logic             sda_change_stb,
  input logic             sda_sample_stb,
  input logic             tick,
  input logic             period_start,
  input logic             rel_wait,
  input logic [CNT_W-1:0] lat_high,
  input logic [CNT_W-1:0] lat_low,
  input logic [CNT_W-1:0] lat_cyc,
  input logic [DIV_W-1:0] lat_div
);

  a_r7_change_in_low: assert property (@(posedge clk) disable iff (!rst_n)
    sda_change_stb |-> scl_pull_low);

  a_r8_sample_when_high: assert property (@(posedge clk) disable iff (!rst_n)
    sda_sample_stb |-> (!scl_pull_low && scl_in));

  a_r6_stretch_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_wait && !scl_in) |=> (rel_wait && !scl_pull_low));

  a_r10_gate_keeps_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!ser_clk_en && scl_pull_low) |=> scl_pull_low);

  a_r10_no_tick_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_clk_en |-> !tick);

  a_r9_cfg_held: assert property (@(posedge clk) disable iff (!rst_n)
    !period_start |=> $stable({lat_high, lat_low, lat_cyc, lat_div}));

  a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_pull_low && !ser_clk_en && !rel_wait) |=> !sda_change_stb);

endmodule

bind scl_timing_gen scl_timing_chk #(.CNT_W(CNT_W), .DIV_W(DIV_W)) i_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .ser_clk_en     (ser_clk_en),
  .scl_in         (scl_in),
  .scl_pull_low   (scl_pull_low),
  .sda_change_stb (sda_change_stb),
  .sda_sample_stb (sda_sample_stb),
  .tick           (tick),
  .period_start   (period_start),
  .rel_wait       (rel_wait),
  .lat_high       (lat_high),
  .lat_low        (lat_low),
  .lat_cyc        (lat_cyc),
  .lat_div        (lat_div)
);

// File: tb/test_scl_timing_gen.sv
module test_scl_timing_gen;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 10;
  localparam int DIV_W = 8;
  localparam int CFG_W = 3 * CNT_W;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [CFG_W-1:0] cfg_word;
  logic [DIV_W-1:0] div_value;
  logic             ser_clk_en = 1'b0;
  logic             hold = 1'b0;
  logic             scl_in;
  logic             scl_pull_low;
  logic             sda_change_stb;
  logic             sda_sample_stb;

  // Open-drain bus: low if the master or a stretching target pulls it
  assign scl_in = ~(scl_pull_low | hold);

  always #(CLK_PERIOD/2) clk = ~clk;

  scl_timing_gen #(.CNT_W(CNT_W), .DIV_W(DIV_W)) i_scl_timing_gen (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_word       (cfg_word),
    .div_value      (div_value),
    .ser_clk_en     (ser_clk_en),
    .scl_in         (scl_in),
    .scl_pull_low   (scl_pull_low),
    .sda_change_stb (sda_change_stb),
    .sda_sample_stb (sda_sample_stb)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done_flag = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // Reference arithmetic, restated from the requirements
  function automatic int ref_eff(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic int ref_low(input int h, input int l, input int c);
    int hh = ref_eff(h);
    int ll = ref_eff(l);
    return (c - hh > ll) ? c - hh : ll;
  endfunction

  function automatic int ref_mid(input int n);
    return (n + 1) / 2;
  endfunction

  function automatic logic [CFG_W-1:0] pack_cfg(input int h, input int l, input int c);
    return {CNT_W'(h), CNT_W'(l), CNT_W'(c)};
  endfunction

  // Period monitor, sampling on the falling edge
  bit mon_on = 0;
  bit prev_pl = 0;
  bit have_rel = 0;
  int period_cnt = 0;
  int low_len, rel_len, gate_cnt, stretch_cnt;
  int chg_cnt, chg_pos, smp_cnt, smp_pos;
  int act_h, act_l, act_c, act_d;

  always @(negedge clk) begin
    if (mon_on) begin
      if (scl_pull_low && !prev_pl) begin
        if (have_rel) begin
          check(rel_len == ref_eff(act_h) * act_d + 1 + stretch_cnt,
                "R5 release length", rel_len, ref_eff(act_h) * act_d + 1 + stretch_cnt);
          check(smp_cnt == 1, "R8 sample strobes per period", smp_cnt, 1);
          check(smp_pos == stretch_cnt + 1, "R6 sample after stretch", smp_pos, stretch_cnt + 1);
        end
        act_h = int'(cfg_word[3*CNT_W-1:2*CNT_W]);
        act_l = int'(cfg_word[2*CNT_W-1:CNT_W]);
        act_c = int'(cfg_word[CNT_W-1:0]);
        act_d = ref_eff(int'(div_value));
        period_cnt++;
        low_len = 0; gate_cnt = 0; chg_cnt = 0; chg_pos = 0;
      end
      if (!scl_pull_low && prev_pl) begin
        check(low_len == ref_low(act_h, act_l, act_c) * act_d + gate_cnt,
              "R4 R2 R3 R9 R10 low length", low_len,
              ref_low(act_h, act_l, act_c) * act_d + gate_cnt);
        check(chg_cnt == 1, "R7 change strobes per low", chg_cnt, 1);
        if (gate_cnt == 0)
          check(chg_pos == ref_mid(ref_low(act_h, act_l, act_c)) * act_d,
                "R7 change strobe position", chg_pos,
                ref_mid(ref_low(act_h, act_l, act_c)) * act_d);
        rel_len = 0; stretch_cnt = 0; smp_cnt = 0; smp_pos = 0;
        have_rel = 1;
      end
      if (scl_pull_low) begin
        low_len++;
        if (!ser_clk_en) gate_cnt++;
        if (sda_change_stb) begin
          chg_cnt++;
          if (chg_pos == 0) chg_pos = low_len;
        end
      end else if (have_rel) begin
        rel_len++;
        if (!scl_in && smp_cnt == 0) stretch_cnt++;
        if (sda_sample_stb) begin
          smp_cnt++;
          if (smp_pos == 0) smp_pos = rel_len;
        end
      end
      prev_pl = scl_pull_low;
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wait_new_period();
    int last = period_cnt;
    while (period_cnt == last) step();
  endtask

  // Hold SCL low across the release for s released clocks
  task automatic stretch_for(input int s);
    if (s > 0) begin
      hold = 1'b1;
      while (scl_pull_low) step();
      repeat (s) step();
      hold = 1'b0;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    finish_run();
  end

  initial begin
    int seed;
    seed = $urandom(32'h1c5c);
    cfg_word  = pack_cfg(10, 11, 26);
    div_value = DIV_W'(7);

    // R1: outputs quiet under reset
    repeat (3) begin
      @(negedge clk);
      check(!scl_pull_low && !sda_change_stb && !sda_sample_stb, "R1 reset outputs",
            {scl_pull_low, sda_change_stb, sda_sample_stb}, 0);
    end
    step();
    rst_n = 1'b1;

    // R1: idle until enabled
    repeat (12) begin
      @(negedge clk);
      check(!scl_pull_low && !sda_change_stb, "R1 idle while disabled",
            {scl_pull_low, sda_change_stb}, 0);
    end
    mon_on = 1;
    step();
    ser_clk_en = 1'b1;

    // Standard 100 kHz timing, with a gated stretch of the low phase (R10)
    wait_new_period();
    wait_new_period();
    repeat (5) step();
    ser_clk_en = 1'b0;
    repeat (6) step();
    ser_clk_en = 1'b1;

    // 400 kHz applied mid-period: must wait for next period (R9)
    wait_new_period();
    cfg_word  = pack_cfg(5, 12, 24);
    div_value = DIV_W'(2);
    wait_new_period();
    wait_new_period();
    // 1 MHz
    cfg_word  = pack_cfg(3, 9, 18);
    div_value = DIV_W'(1);
    wait_new_period();
    wait_new_period();
    // Zero counts and zero divider (R2 R3)
    cfg_word  = pack_cfg(0, 0, 0);
    div_value = DIV_W'(0);
    wait_new_period();
    wait_new_period();
    // Low count exceeds period minus high: no extra low time (R4)
    cfg_word  = pack_cfg(4, 20, 10);
    div_value = DIV_W'(3);
    wait_new_period();
    wait_new_period();
    // Directed target stretch (R6)
    cfg_word  = pack_cfg(3, 5, 0);
    div_value = DIV_W'(2);
    wait_new_period();
    wait_new_period();
    stretch_for(7);
    wait_new_period();

    // Constrained random periods
    for (int p = 0; p < 40; p++) begin
      cfg_word  = pack_cfg($urandom_range(0, 12), $urandom_range(0, 12), $urandom_range(0, 30));
      div_value = DIV_W'($urandom_range(0, 4));
      stretch_for($urandom_range(0, 4));
      wait_new_period();
    end
    wait_new_period();
    wait_new_period();

    check(period_cnt >= 50, "R5 periods completed", period_cnt, 50);
    finish_run();
  end

endmodule